// File: doc/BRIEF.md
# Lockable Region Protection Unit

This block guards a 32-bit address space with an ordered table of protection entries. Each entry holds a region start address, aligned to 32 bytes. A region runs from its own start up to the start of the next entry. A check request gives an address, an access kind and a privilege level. One cycle later the block returns an allow or deny verdict, together with the 9-bit memory type of the region that matched. The verdict is decided by the entry with the highest index that is enabled and whose start lies at or below the checked address.

Entries are loaded through one write port, which takes two 32-bit words together. The first word carries the start address plus the enable and lock flags. The second word carries the target entry index, a 4-bit rights code and the memory type. The rights code is decoded as one enumerated value: its bits are not separate flags. When an entry is locked, it becomes frozen until reset. A locked entry also pins the start address of the entry directly above it.

A write is refused when any of its reserved fields is non-zero. Such a write leaves the table unchanged and sets a sticky error flag, which stays set until it is cleared by a separate input.

Top module: `region_guard`

## Requirements
- R1: A write applies to the entry whose index is in attribute-word bits 4:0. The address word gives the start address in bits 31:5 and the enable flag in bit 0. The attribute word gives the rights code in bits 11:8 and the memory type in bits 20:12. A write whose index is at or above the entry count changes nothing.
- R2: A check is decided by the enabled entry with the highest index whose start address is less than or equal to the checked address, with both compared at bit 5 and above. A disabled entry is skipped, so the region below it carries on across its range.
- R3: `chk_done` goes high exactly one cycle after a cycle in which `chk_valid` is high, and the verdict outputs are valid in that same cycle.
- R4: When no enabled entry matches the address, the check returns `chk_hit`=0, `chk_allow`=0 and `chk_memtype`=0. This is also the case straight after reset.
- R5: In kernel mode (`chk_user`=0) the rights codes grant the following. 2 grants x only. 4 grants r. 5 grants r,x. 6 grants r,w. 7 grants r,w,x. 8 grants w. 9 and 10 grant r,w. 11 grants r,w,x. 12 grants r. 13 grants r,x. 14 grants r,w. 15 grants r,w,x.
- R6: In user mode (`chk_user`=1) the rights codes grant the following. 3 grants x only. 8 grants w. 9 grants r,w,x. 10 grants r. 11 grants r,x. 12 grants r. 13 grants r,x. 14 grants r,w. 15 grants r,w,x. Codes 2 and 4 to 7 grant nothing.
- R7: Access kind is encoded as 0 = read, 1 = write, 2 = execute. Kind code 3 is always denied. Rights codes 0 and 1 deny every access in both modes.
- R8: Bit i of `enable_mask` equals the enable flag of the last write accepted for entry i. It is 0 after reset.
- R9: An accepted write whose address-word bit 1 is set locks its entry. Every later write to a locked entry is ignored, including a write that tries to clear its enable flag.
- R10: When entry i-1 is locked, a write to entry i that would change the start address of entry i is ignored. A write to entry i that keeps the same start address is accepted.
- R11: A write with non-zero address-word bits 4:2, attribute-word bits 7:5 or attribute-word bits 31:21 is rejected and sets `err_sticky`. `err_sticky` stays set until `err_clear` is high in a cycle with no such write. If a rejected write and `err_clear` fall in the same cycle, the flag is set.
- R12: Locks are released only by reset. After reset, every entry accepts writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load an entry from the two words |
| wr_addr_word | input | 32 | Start address, lock flag and enable flag |
| wr_attr_word | input | 32 | Entry index, rights code and memory type |
| err_clear | input | 1 | Clears the sticky error flag |
| chk_valid | input | 1 | Check request strobe |
| chk_addr | input | 32 | Address to check |
| chk_kind | input | 2 | 0 read, 1 write, 2 execute |
| chk_user | input | 1 | 1 for user mode, 0 for kernel mode |
| chk_done | output | 1 | Verdict valid, one cycle after the request |
| chk_allow | output | 1 | Access allowed |
| chk_hit | output | 1 | An enabled entry matched |
| chk_memtype | output | 9 | Memory type of the matched region, or 0 |
| enable_mask | output | NUM_ENTRIES | Enable flag of each entry |
| err_sticky | output | 1 | A malformed write was rejected |

## Verification
The rights decode is tried by loading every one of the 16 codes into a region that covers all of memory. Each code is then checked for all three access kinds in both modes. This separates codes that differ in a single permission bit, and it shows whether the kernel and user columns have been swapped.

Region selection is tried on a staggered layout with a disabled entry in the middle. The probe addresses are:
- the last address below the first region, which must give no hit;
- the first and last address of a region;
- an address inside the disabled entry's range, which must fall back to the entry below;
- the top of memory.

Lock behaviour is tried in three ways: by rewriting the locked entry, by moving the following entry's start, and by rewriting the following entry with its start unchanged. Together these show that only the start address of the next entry is frozen, and that the rest of that entry can still be written.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

    localparam int START_W = 27;
    localparam int MTYPE_W = 9;
    localparam int CODE_W  = 4;
    localparam int SLOT_W  = 5;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        perm_t kern;
        perm_t usr;
    } rights_t;

    typedef struct packed {
        logic [START_W-1:0] start;
        logic [CODE_W-1:0]  code;
        logic [MTYPE_W-1:0] mtype;
    } slot_t;

    function automatic perm_t mk(input logic r, input logic w, input logic x);
        perm_t p;
        p.r = r;
        p.w = w;
        p.x = x;
        return p;
    endfunction

    function automatic rights_t decode_rights(input logic [CODE_W-1:0] code);
        rights_t rt;
        rt.kern = mk(1'b0, 1'b0, 1'b0);
        rt.usr  = mk(1'b0, 1'b0, 1'b0);
        unique case (code)
            4'd2:  rt.kern = mk(1'b0, 1'b0, 1'b1);
            4'd3:  rt.usr  = mk(1'b0, 1'b0, 1'b1);
            4'd4:  rt.kern = mk(1'b1, 1'b0, 1'b0);
            4'd5:  rt.kern = mk(1'b1, 1'b0, 1'b1);
            4'd6:  rt.kern = mk(1'b1, 1'b1, 1'b0);
            4'd7:  rt.kern = mk(1'b1, 1'b1, 1'b1);
            4'd8:  begin rt.kern = mk(1'b0, 1'b1, 1'b0); rt.usr = mk(1'b0, 1'b1, 1'b0); end
            4'd9:  begin rt.kern = mk(1'b1, 1'b1, 1'b0); rt.usr = mk(1'b1, 1'b1, 1'b1); end
            4'd10: begin rt.kern = mk(1'b1, 1'b1, 1'b0); rt.usr = mk(1'b1, 1'b0, 1'b0); end
            4'd11: begin rt.kern = mk(1'b1, 1'b1, 1'b1); rt.usr = mk(1'b1, 1'b0, 1'b1); end
            4'd12: begin rt.kern = mk(1'b1, 1'b0, 1'b0); rt.usr = mk(1'b1, 1'b0, 1'b0); end
            4'd13: begin rt.kern = mk(1'b1, 1'b0, 1'b1); rt.usr = mk(1'b1, 1'b0, 1'b1); end
            4'd14: begin rt.kern = mk(1'b1, 1'b1, 1'b0); rt.usr = mk(1'b1, 1'b1, 1'b0); end
            4'd15: begin rt.kern = mk(1'b1, 1'b1, 1'b1); rt.usr = mk(1'b1, 1'b1, 1'b1); end
            default: ;
        endcase
        return rt;
    endfunction

    function automatic logic reserved_bad(input logic [31:0] aw, input logic [31:0] tw);
        return (|aw[4:2]) || (|tw[7:5]) || (|tw[31:21]);
    endfunction

endpackage

// File: rtl/region_table.sv
module region_table
    import region_guard_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [31:0]            wr_addr_word,
    input  logic [31:0]            wr_attr_word,
    input  logic                   err_clear,
    output slot_t [NUM_ENTRIES-1:0] slots,
    output logic [NUM_ENTRIES-1:0] en_vec,
    output logic [NUM_ENTRIES-1:0] lock_vec,
    output logic                   err_flag
);

    logic [SLOT_W-1:0]  tgt;
    logic [START_W-1:0] new_start;
    logic               bad_fmt;
    logic               self_frozen;
    logic               start_frozen;
    logic               in_range;
    logic               accept;
    slot_t              new_slot;

    assign tgt       = wr_attr_word[4:0];
    assign new_start = wr_addr_word[31:5];
    assign bad_fmt   = reserved_bad(wr_addr_word, wr_attr_word);
    assign in_range  = (32'(tgt) < 32'(NUM_ENTRIES));

    assign new_slot.start = new_start;
    assign new_slot.code  = wr_attr_word[11:8];
    assign new_slot.mtype = wr_attr_word[20:12];

    always_comb begin
        self_frozen  = 1'b0;
        start_frozen = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (tgt == SLOT_W'(i)) begin
                self_frozen = lock_vec[i];
                if (i > 0) begin
                    start_frozen = lock_vec[i-1] && (slots[i].start != new_start);
                end
            end
        end
    end

    assign accept = wr_en && !bad_fmt && in_range && !self_frozen && !start_frozen;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g]    <= '0;
                en_vec[g]   <= 1'b0;
                lock_vec[g] <= 1'b0;
            end else if (accept && (tgt == SLOT_W'(g))) begin
                slots[g]    <= new_slot;
                en_vec[g]   <= wr_addr_word[0];
                lock_vec[g] <= wr_addr_word[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
        end else if (wr_en && bad_fmt) begin
            err_flag <= 1'b1;
        end else if (err_clear) begin
            err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/region_match.sv
module region_match
    import region_guard_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  slot_t [NUM_ENTRIES-1:0] slots,
    input  logic [NUM_ENTRIES-1:0]  en_vec,
    input  logic [31:0]             addr,
    output logic                    hit,
    output slot_t                   sel
);

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (en_vec[i] && (slots[i].start <= addr[31:5])) begin
                hit = 1'b1;
                sel = slots[i];
            end
        end
    end

endmodule

// File: rtl/access_decide.sv
module access_decide
    import region_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               hit,
    input  slot_t              sel,
    input  logic [1:0]         kind,
    input  logic               user,
    output logic               done_q,
    output logic               allow_q,
    output logic               hit_q,
    output logic [MTYPE_W-1:0] mtype_q
);

    rights_t rt;
    perm_t   p;
    logic    granted;

    assign rt = decode_rights(sel.code);
    assign p  = user ? rt.usr : rt.kern;

    always_comb begin
        unique case (kind)
            ACC_READ:  granted = p.r;
            ACC_WRITE: granted = p.w;
            ACC_EXEC:  granted = p.x;
            default:   granted = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            allow_q <= 1'b0;
            hit_q   <= 1'b0;
            mtype_q <= '0;
        end else begin
            done_q <= req;
            if (req) begin
                allow_q <= hit && granted;
                hit_q   <= hit;
                mtype_q <= hit ? sel.mtype : '0;
            end
        end
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import region_guard_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [31:0]            wr_addr_word,
    input  logic [31:0]            wr_attr_word,
    input  logic                   err_clear,
    input  logic                   chk_valid,
    input  logic [31:0]            chk_addr,
    input  logic [1:0]             chk_kind,
    input  logic                   chk_user,
    output logic                   chk_done,
    output logic                   chk_allow,
    output logic                   chk_hit,
    output logic [8:0]             chk_memtype,
    output logic [NUM_ENTRIES-1:0] enable_mask,
    output logic                   err_sticky
);

    slot_t [NUM_ENTRIES-1:0] slots;
    logic [NUM_ENTRIES-1:0]  lock_vec;
    logic                    m_hit;
    slot_t                   m_sel;

    region_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr_word (wr_addr_word),
        .wr_attr_word (wr_attr_word),
        .err_clear    (err_clear),
        .slots        (slots),
        .en_vec       (enable_mask),
        .lock_vec     (lock_vec),
        .err_flag     (err_sticky)
    );

    region_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .slots  (slots),
        .en_vec (enable_mask),
        .addr   (chk_addr),
        .hit    (m_hit),
        .sel    (m_sel)
    );

    access_decide u_decide (
        .clk     (clk),
        .rst     (rst),
        .req     (chk_valid),
        .hit     (m_hit),
        .sel     (m_sel),
        .kind    (chk_kind),
        .user    (chk_user),
        .done_q  (chk_done),
        .allow_q (chk_allow),
        .hit_q   (chk_hit),
        .mtype_q (chk_memtype)
    );

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
    parameter int NUM_ENTRIES = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [31:0]            wr_addr_word,
    input logic [31:0]            wr_attr_word,
    input logic                   err_clear,
    input logic                   chk_valid,
    input logic                   chk_done,
    input logic                   chk_allow,
    input logic                   chk_hit,
    input logic [8:0]             chk_memtype,
    input logic [NUM_ENTRIES-1:0] enable_mask,
    input logic [NUM_ENTRIES-1:0] lock_vec,
    input logic                   err_sticky
);

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> chk_done) else $error("AST_DONE_AFTER_REQ"); // R3

    AST_NO_REQ_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !chk_done) else $error("AST_NO_REQ_NO_DONE"); // R3

    AST_MISS_DENIES: assert property (@(posedge clk) disable iff (rst)
        (chk_done && !chk_hit) |-> (!chk_allow && chk_memtype == 9'd0))
        else $error("AST_MISS_DENIES"); // R4

    AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (|lock_vec) |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)))
        else $error("AST_LOCK_KEPT"); // R12

    AST_LOCKED_EN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (|lock_vec) |=> ((enable_mask & $past(lock_vec)) == ($past(enable_mask) & $past(lock_vec))))
        else $error("AST_LOCKED_EN_FROZEN"); // R9

    AST_BAD_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((|wr_addr_word[4:2]) || (|wr_attr_word[7:5]) || (|wr_attr_word[31:21])))
        |=> err_sticky) else $error("AST_BAD_WRITE_FLAGS"); // R11

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !err_clear) |=> err_sticky) else $error("AST_ERR_HOLDS"); // R11

endmodule

bind region_guard region_guard_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr_word (wr_addr_word),
    .wr_attr_word (wr_attr_word),
    .err_clear    (err_clear),
    .chk_valid    (chk_valid),
    .chk_done     (chk_done),
    .chk_allow    (chk_allow),
    .chk_hit      (chk_hit),
    .chk_memtype  (chk_memtype),
    .enable_mask  (enable_mask),
    .lock_vec     (lock_vec),
    .err_sticky   (err_sticky)
);

// File: tb/region_guard_bench.sv
`timescale 1ns/1ps
module region_guard_bench;

    localparam int N = 8;
    localparam realtime HALF = 10.0;

    // per rights code: {kr, kw, kx, ur, uw, ux}
    localparam logic [5:0] PERM [16] = '{
        6'b000000, 6'b000000, 6'b001000, 6'b000001,
        6'b100000, 6'b101000, 6'b110000, 6'b111000,
        6'b010010, 6'b110111, 6'b110100, 6'b111101,
        6'b100100, 6'b101101, 6'b110110, 6'b111111
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr_word = '0;
    logic [31:0] wr_attr_word = '0;
    logic        err_clear = 1'b0;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [1:0]  chk_kind = '0;
    logic        chk_user = 1'b0;
    logic        chk_done;
    logic        chk_allow;
    logic        chk_hit;
    logic [8:0]  chk_memtype;
    logic [N-1:0] enable_mask;
    logic        err_sticky;

    int total = 0;
    int fails = 0;

    always #(HALF) clk = ~clk;

    region_guard #(.NUM_ENTRIES(N)) u_region_guard (.*);

    function automatic logic [31:0] aw(input logic [31:0] a, input logic lk, input logic en);
        return {a[31:5], 3'b000, lk, en};
    endfunction

    function automatic logic [31:0] tw(input int idx, input logic [3:0] code, input logic [8:0] mt);
        return {11'd0, mt, code, 3'b000, 5'(idx)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr_word = a; wr_attr_word = t;
        @(negedge clk);
        wr_en = 1'b0; wr_addr_word = '0; wr_attr_word = '0;
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] k, input logic u);
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = a; chk_kind = k; chk_user = u;
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    // probe and compare hit, allow, memtype
    task automatic expect_chk(input string tag, input logic [31:0] a, input logic [1:0] k,
                              input logic u, input logic eh, input logic ea, input logic [8:0] em);
        probe(a, k, u);
        check({tag, " done"}, 32'(chk_done), 32'd1);
        check({tag, " hit/allow/mt"}, {20'd0, chk_hit, chk_allow, 1'b0, chk_memtype},
              {20'd0, eh, ea, 1'b0, em});
    endtask

    initial begin
        #(HALF * 2 * 200000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4 R8 R11 reset state
        check("R8 reset mask", 32'(enable_mask), 32'd0);
        check("R11 reset err", 32'(err_sticky), 32'd0);
        expect_chk("R4 miss after reset", 32'h0000_4000, 2'd0, 1'b0, 1'b0, 1'b0, 9'd0);

        // R3 latency: done high only in the cycle after the request
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = 32'h0; chk_kind = 2'd0; chk_user = 1'b0;
        check("R3 done not early", 32'(chk_done), 32'd0);
        @(negedge clk);
        chk_valid = 1'b0;
        check("R3 done on time", 32'(chk_done), 32'd1);
        @(negedge clk);
        check("R3 done drops", 32'(chk_done), 32'd0);

        // R5 R6 R7 rights table walk over a region covering all memory
        for (int c = 0; c < 16; c++) begin
            wr(aw(32'h0, 1'b0, 1'b1), tw(0, 4'(c), 9'(c * 3 + 1)));
            for (int u = 0; u < 2; u++) begin
                for (int k = 0; k < 3; k++) begin
                    logic exp_a;
                    exp_a = PERM[c][(u == 1 ? 2 : 5) - k];
                    expect_chk(u == 1 ? "R6 user rights" : "R5 kernel rights",
                               32'h1234_5660, 2'(k), u[0], 1'b1, exp_a, 9'(c * 3 + 1));
                end
            end
        end
        // R7 kind code 3 always denied
        expect_chk("R7 kind 3 denied", 32'h40, 2'd3, 1'b0, 1'b1, 1'b0, 9'd46);

        // R1 R2 staggered layout
        wr(aw(32'h1000, 1'b0, 1'b1), tw(0, 4'd15, 9'd1));
        wr(aw(32'h2000, 1'b0, 1'b1), tw(1, 4'd12, 9'd2));
        wr(aw(32'h3000, 1'b0, 1'b0), tw(2, 4'd15, 9'd3));
        wr(aw(32'h4000, 1'b0, 1'b1), tw(3, 4'd14, 9'd4));
        check("R8 mask after layout", 32'(enable_mask), 32'h0B);
        expect_chk("R4 below first region", 32'h0FFF, 2'd0, 1'b0, 1'b0, 1'b0, 9'd0);
        expect_chk("R2 region start", 32'h1000, 2'd2, 1'b0, 1'b1, 1'b1, 9'd1);
        expect_chk("R2 region last byte", 32'h1FFF, 2'd1, 1'b1, 1'b1, 1'b1, 9'd1);
        expect_chk("R2 next region", 32'h2000, 2'd1, 1'b1, 1'b1, 1'b0, 9'd2);
        expect_chk("R2 skip disabled", 32'h3500, 2'd0, 1'b1, 1'b1, 1'b1, 9'd2);
        expect_chk("R2 top region", 32'h4000, 2'd1, 1'b0, 1'b1, 1'b1, 9'd4);
        expect_chk("R2 top of memory", 32'hFFFF_FFE0, 2'd2, 1'b0, 1'b1, 1'b0, 9'd4);

        // R1 out-of-range index ignored
        wr(aw(32'h0, 1'b0, 1'b1), tw(9, 4'd15, 9'd77));
        check("R1 out of range mask", 32'(enable_mask), 32'h0B);
        expect_chk("R1 out of range no effect", 32'h0800, 2'd0, 1'b0, 1'b0, 1'b0, 9'd0);

        // R11 malformed writes
        wr(aw(32'h0, 1'b0, 1'b1) | 32'h4, tw(5, 4'd15, 9'd5));
        check("R11 err set", 32'(err_sticky), 32'd1);
        check("R11 rejected write mask", 32'(enable_mask), 32'h0B);
        @(negedge clk);
        check("R11 err holds", 32'(err_sticky), 32'd1);
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
        check("R11 err cleared", 32'(err_sticky), 32'd0);
        @(negedge clk);
        wr_en = 1'b1; err_clear = 1'b1;
        wr_addr_word = aw(32'h0, 1'b0, 1'b1);
        wr_attr_word = tw(6, 4'd15, 9'd5) | 32'h8000_0000;
        @(negedge clk);
        wr_en = 1'b0; err_clear = 1'b0; wr_addr_word = '0; wr_attr_word = '0;
        check("R11 set wins over clear", 32'(err_sticky), 32'd1);
        check("R11 high field rejected", 32'(enable_mask), 32'h0B);
        wr(aw(32'h0, 1'b0, 1'b1), tw(6, 4'd15, 9'd5) | 32'h20);
        check("R11 attr low field rejected", 32'(enable_mask), 32'h0B);

        // R9 R10 lock behaviour
        wr(aw(32'h2000, 1'b1, 1'b1), tw(1, 4'd12, 9'd2));
        wr(aw(32'h2000, 1'b0, 1'b1), tw(1, 4'd15, 9'd9));
        expect_chk("R9 locked rights kept", 32'h2000, 2'd1, 1'b1, 1'b1, 1'b0, 9'd2);
        wr(aw(32'h2000, 1'b0, 1'b0), tw(1, 4'd15, 9'd9));
        check("R9 locked enable kept", 32'(enable_mask), 32'h0B);
        wr(aw(32'h2800, 1'b0, 1'b1), tw(2, 4'd15, 9'd7));
        check("R10 moved start ignored mask", 32'(enable_mask), 32'h0B);
        expect_chk("R10 moved start ignored", 32'h2900, 2'd0, 1'b0, 1'b1, 1'b1, 9'd2);
        wr(aw(32'h3000, 1'b0, 1'b1), tw(2, 4'd15, 9'd7));
        check("R10 same start accepted mask", 32'(enable_mask), 32'h0F);
        expect_chk("R10 same start accepted", 32'h3000, 2'd1, 1'b1, 1'b1, 1'b1, 9'd7);
        expect_chk("R10 locked region below", 32'h2FE0, 2'd1, 1'b1, 1'b1, 1'b0, 9'd2);

        // R12 reset releases locks
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R12 mask cleared", 32'(enable_mask), 32'd0);
        wr(aw(32'h2000, 1'b0, 1'b1), tw(1, 4'd15, 9'd5));
        wr(aw(32'h2000, 1'b0, 1'b1), tw(1, 4'd15, 9'd6));
        expect_chk("R12 entry writable again", 32'h2000, 2'd0, 1'b0, 1'b1, 1'b1, 9'd6);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule